// File: doc/BRIEF.md
# NAND Flash Command and Status Responder

This block sits on the device side of an 8-bit multiplexed flash bus and plays the part of a flash chip's command register. It is meant as a peer for a controller under test or as the front end of a flash emulator. Each write cycle on the bus arrives as a one-clock strobe that carries the command-latch and address-latch qualifiers and a byte. The responder decodes these as command, address or data cycles. It holds a small page buffer, a one-time-programmable (OTP) page store and a busy timer, and it drives a ready/busy pin that is low while an operation is running.

Read cycles are requests on `rd_req`. Each request is answered with one byte exactly one clock later, marked by `rd_valid`. The returned byte depends on the last accepted command: the status byte, the five identification bytes in turn, or page-buffer data from an auto-incrementing column pointer. The read stream has no back-pressure. The host may issue a request on every clock and must take each byte in the cycle when `rd_valid` is high. Read requests and write strobes are never issued in the same clock.

Array storage beyond the page buffer is not modelled. An ordinary program or erase only produces its busy period. An ordinary page read leaves the buffer as it is. In OTP mode, a read loads the buffer from the OTP store.

Top module: `nand_status_responder`

## Requirements
- R1: After reset `rb_n` is 1, the page buffer holds FFh, read requests return page data, and command 00h counts as already latched, so a read can start directly with address cycles.
- R2: Command 90h followed by address byte 00h makes successive reads return C8h, DCh, 90h, 95h, 54h, after which the sequence restarts at C8h. Any other address byte makes these reads return 00h.
- R3: After command 70h or F1h, every read returns the status byte until another command is accepted. Status bit 7 is `wp_n`, bit 6 is 1 when ready, bit 0 is the fail flag, and bits 5 to 1 are 0.
- R4: While busy, only commands 70h, F1h and FFh are accepted. All other commands, address cycles and data cycles are ignored. Page-data reads during busy return FFh and do not advance the column.
- R5: Command FFh is accepted at any time. It aborts a pending operation, clears the fail flag, returns the latched command to 00h, and holds `rb_n` low for RST_CYC clocks, including when issued from the ready state. It does not change OTP mode or the OTP lock.
- R6: Confirm commands 30h (after 00h and five address cycles), 10h (after 80h and five address cycles) and D0h (after 60h and three address cycles) hold `rb_n` low for READ_CYC, PROG_CYC and ERASE_CYC clocks.
- R7: After 80h, the first address byte's low bits set the column. Each following data cycle writes the buffer at the column and advances it, wrapping modulo PAGE_BYTES. After 00h, address cycles and 30h, reads return the buffer from the addressed column onward.
- R8: Command EFh, then address byte 90h, then a data byte 01h enters OTP mode, 00h leaves it, and 03h locks the OTP store permanently. After leaving OTP mode, program and erase no longer report OTP failures.
- R9: In OTP mode, the third address byte selects the page. A program succeeds only if the page is below OTP_PAGES, the store is unlocked, and the page is above every page already written. A successful program stores the buffer when the busy period ends. Any other program sets status bit 0 and leaves the store unchanged. An erase in OTP mode sets status bit 0 and does not go busy. A read in OTP mode loads the page into the buffer.
- R10: Address cycles beyond the count a command needs (five for 00h and 80h, three for 60h, one for 90h and EFh) are ignored.
- R11: Each `rd_req` produces `rd_valid` with its byte on the next clock, and `rd_valid` is low in every other clock.
- R12: With `wp_n` low, the 10h and D0h confirms start nothing and leave `rb_n` high, and status bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | One-clock write strobe, marking the end of a write cycle |
| bus_cle | input | 1 | Command qualifier for the write strobe |
| bus_ale | input | 1 | Address qualifier for the write strobe |
| bus_din | input | 8 | Byte carried by the write cycle |
| wp_n | input | 1 | Write protect, active low |
| rd_req | input | 1 | Read-cycle request |
| rd_valid | output | 1 | Returned byte valid, one clock after `rd_req` |
| rd_data | output | 8 | Returned byte |
| rb_n | output | 1 | Ready (1) or busy (0) |

## Verification
The embedded assertions check on every cycle that:
- a command rejected during busy leaves the latched command and the output mode untouched;
- FFh always brings busy and a cleared fail flag;
- the address count saturates;
- the OTP write limit never moves back and the lock never clears;
- commits stay inside the OTP store;
- the timer goes busy when started;
- `rd_valid` follows `rd_req` by exactly one clock.

Only the directed scenarios can show the exact busy lengths, the identification and status byte values, the column wrap, and the OTP ordering, lock and abort outcomes. The same holds for status and page reads that respond to `wp_n`.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;

  typedef enum logic [1:0] {
    OUT_PAGE   = 2'd0,
    OUT_STATUS = 2'd1,
    OUT_ID     = 2'd2
  } out_kind_e;

  localparam logic [7:0] C_READ1   = 8'h00;
  localparam logic [7:0] C_READ2   = 8'h30;
  localparam logic [7:0] C_PROG1   = 8'h80;
  localparam logic [7:0] C_PROG2   = 8'h10;
  localparam logic [7:0] C_ERASE1  = 8'h60;
  localparam logic [7:0] C_ERASE2  = 8'hD0;
  localparam logic [7:0] C_STAT    = 8'h70;
  localparam logic [7:0] C_STAT2   = 8'hF1;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_RESET   = 8'hFF;
  localparam logic [7:0] C_FEATURE = 8'hEF;
  localparam logic [7:0] FEAT_OTP  = 8'h90;

  function automatic logic [7:0] ident_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'hC8;
      3'd1:    return 8'hDC;
      3'd2:    return 8'h90;
      3'd3:    return 8'h95;
      3'd4:    return 8'h54;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= len;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1)) && !start;

  // R6: a started timer is busy on the following cycle
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len != '0) |=> busy);
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
  parameter int PAGE_BYTES = 8,
  parameter int OTP_PAGES  = 30
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(PAGE_BYTES)-1:0] wr_col,
  input  logic [7:0]                    wr_data,
  input  logic                          commit_en,
  input  logic                          load_en,
  input  logic [7:0]                    sel_pg,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_col,
  output logic [7:0]                    rd_byte
);
  localparam int OTP_IW = $clog2(OTP_PAGES);
  localparam logic [7:0] PG_LIM = 8'(OTP_PAGES);

  logic [7:0] buf_q [PAGE_BYTES];
  logic [7:0] otp_q [OTP_PAGES][PAGE_BYTES];
  logic       pg_in;

  assign pg_in = (sel_pg < PG_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < PAGE_BYTES; b++) buf_q[b] <= 8'hFF;
    end else if (load_en) begin
      for (int b = 0; b < PAGE_BYTES; b++)
        buf_q[b] <= pg_in ? otp_q[sel_pg[OTP_IW-1:0]][b] : 8'hFF;
    end else if (wr_en) begin
      buf_q[wr_col] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < OTP_PAGES; p++)
        for (int b = 0; b < PAGE_BYTES; b++) otp_q[p][b] <= 8'hFF;
    end else if (commit_en && pg_in) begin
      for (int b = 0; b < PAGE_BYTES; b++) otp_q[sel_pg[OTP_IW-1:0]][b] <= buf_q[b];
    end
  end

  assign rd_byte = buf_q[rd_col];

  // R9: commits only target pages inside the OTP store
  a_r9_commit_range: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> pg_in);
endmodule

// File: rtl/nand_read_port.sv
module nand_read_port
  import nand_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_req,
  input  out_kind_e  kind,
  input  logic [7:0] status,
  input  logic [2:0] id_idx,
  input  logic       id_ok,
  input  logic       busy,
  input  logic [7:0] page_byte,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  logic [7:0] sel;

  always_comb begin
    case (kind)
      OUT_STATUS: sel = status;
      OUT_ID:     sel = id_ok ? ident_byte(id_idx) : 8'h00;
      default:    sel = busy ? 8'hFF : page_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= sel;
    end
  end

  // R11: one returned byte per request, one cycle later
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
endmodule

// File: rtl/nand_status_responder.sv
module nand_status_responder
  import nand_resp_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int OTP_PAGES  = 30,
  parameter int CNT_W      = 16,
  parameter int READ_CYC   = 20,
  parameter int PROG_CYC   = 40,
  parameter int ERASE_CYC  = 60,
  parameter int RST_CYC    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       bus_cle,
  input  logic       bus_ale,
  input  logic [7:0] bus_din,
  input  logic       wp_n,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rb_n
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam logic [7:0] PG_LIM = 8'(OTP_PAGES);

  logic [7:0]       latch_q, page_q, otp_next_q;
  logic [2:0]       acnt_q, id_idx_q;
  logic [COL_W-1:0] col_q;
  out_kind_e        kind_q;
  logic             id_ok_q, feat_ok_q, otp_mode_q, otp_lock_q, fail_q;
  logic             pend_wr_q, pend_rd_q;

  logic wr_cmd, wr_addr, wr_dat, busy, tmr_done, tmr_start, cmd_ok;
  logic go_rd, go_pg, go_er, go_rst, er_otp_fail, otp_ok, addr_full, row_full;
  logic buf_wr, rd_adv, commit_en, load_en;
  logic [CNT_W-1:0] tmr_len;
  logic [7:0] status, page_byte;

  assign wr_cmd  = bus_we &&  bus_cle && !bus_ale;
  assign wr_addr = bus_we && !bus_cle &&  bus_ale && !busy;
  assign wr_dat  = bus_we && !bus_cle && !bus_ale && !busy;

  assign cmd_ok = wr_cmd && (!busy || bus_din == C_STAT || bus_din == C_STAT2 ||
                             bus_din == C_RESET);
  assign addr_full = (acnt_q >= 3'd5);
  assign row_full  = (acnt_q >= 3'd3);

  assign go_rst = cmd_ok && bus_din == C_RESET;
  assign go_rd  = cmd_ok && bus_din == C_READ2  && latch_q == C_READ1  && addr_full;
  assign go_pg  = cmd_ok && bus_din == C_PROG2  && latch_q == C_PROG1  && addr_full && wp_n;
  assign go_er  = cmd_ok && bus_din == C_ERASE2 && latch_q == C_ERASE1 && row_full &&
                  wp_n && !otp_mode_q;
  assign er_otp_fail = cmd_ok && bus_din == C_ERASE2 && latch_q == C_ERASE1 && row_full &&
                       wp_n && otp_mode_q;
  assign otp_ok = (page_q < PG_LIM) && !otp_lock_q && (page_q >= otp_next_q);

  assign tmr_start = go_rst || go_rd || go_pg || go_er;
  always_comb begin
    if (go_rst)     tmr_len = CNT_W'(RST_CYC);
    else if (go_rd) tmr_len = CNT_W'(READ_CYC);
    else if (go_pg) tmr_len = CNT_W'(PROG_CYC);
    else            tmr_len = CNT_W'(ERASE_CYC);
  end

  assign buf_wr    = wr_dat && latch_q == C_PROG1 && addr_full;
  assign rd_adv    = rd_req && kind_q == OUT_PAGE && !busy;
  assign commit_en = tmr_done && pend_wr_q;
  assign load_en   = tmr_done && pend_rd_q;
  assign status    = {wp_n, !busy, 5'b00000, fail_q};
  assign rb_n      = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= C_READ1;  acnt_q <= '0;  col_q <= '0;  page_q <= '0;
      kind_q <= OUT_PAGE;  id_idx_q <= '0;  id_ok_q <= 1'b0;  feat_ok_q <= 1'b0;
      otp_mode_q <= 1'b0;  otp_lock_q <= 1'b0;  otp_next_q <= '0;  fail_q <= 1'b0;
      pend_wr_q <= 1'b0;   pend_rd_q <= 1'b0;
    end else begin
      if (tmr_done) begin
        pend_wr_q <= 1'b0;
        pend_rd_q <= 1'b0;
        if (pend_wr_q) otp_next_q <= page_q + 8'd1;
      end
      if (cmd_ok) begin
        case (bus_din)
          C_STAT, C_STAT2: kind_q <= OUT_STATUS;
          C_RESET: begin
            latch_q <= C_READ1;  acnt_q <= '0;  col_q <= '0;  kind_q <= OUT_PAGE;
            fail_q <= 1'b0;  pend_wr_q <= 1'b0;  pend_rd_q <= 1'b0;  feat_ok_q <= 1'b0;
          end
          C_READ2: begin
            kind_q <= OUT_PAGE;
            if (go_rd) begin latch_q <= C_READ2; pend_rd_q <= otp_mode_q; end
          end
          C_PROG2: begin
            kind_q <= OUT_PAGE;
            if (go_pg) begin
              latch_q   <= C_PROG2;
              fail_q    <= otp_mode_q && !otp_ok;
              pend_wr_q <= otp_mode_q && otp_ok;
            end
          end
          C_ERASE2: begin
            kind_q <= OUT_PAGE;
            if (go_er || er_otp_fail) begin latch_q <= C_ERASE2; fail_q <= er_otp_fail; end
          end
          C_IDENT: begin
            latch_q <= C_IDENT;  acnt_q <= '0;  kind_q <= OUT_ID;
            id_idx_q <= '0;  id_ok_q <= 1'b0;
          end
          default: begin
            latch_q <= bus_din;  acnt_q <= '0;  kind_q <= OUT_PAGE;  feat_ok_q <= 1'b0;
          end
        endcase
      end else if (wr_addr) begin
        if ((latch_q == C_READ1 || latch_q == C_PROG1) && !addr_full) begin
          if (acnt_q == 3'd0) col_q  <= bus_din[COL_W-1:0];
          if (acnt_q == 3'd2) page_q <= bus_din;
          acnt_q <= acnt_q + 3'd1;
        end else if (latch_q == C_ERASE1 && !row_full) begin
          if (acnt_q == 3'd0) page_q <= bus_din;
          acnt_q <= acnt_q + 3'd1;
        end else if (latch_q == C_IDENT && acnt_q == 3'd0) begin
          id_ok_q <= (bus_din == 8'h00);
          acnt_q  <= 3'd1;
        end else if (latch_q == C_FEATURE && acnt_q == 3'd0) begin
          feat_ok_q <= (bus_din == FEAT_OTP);
          acnt_q    <= 3'd1;
        end
      end else if (wr_dat) begin
        if (buf_wr) col_q <= col_q + 1'b1;
        if (latch_q == C_FEATURE && feat_ok_q) begin
          feat_ok_q <= 1'b0;
          case (bus_din)
            8'h01:   otp_mode_q <= 1'b1;
            8'h00:   otp_mode_q <= 1'b0;
            8'h03:   otp_lock_q <= 1'b1;
            default: ;
          endcase
        end
      end
      if (rd_req && kind_q == OUT_ID) id_idx_q <= (id_idx_q == 3'd4) ? 3'd0 : id_idx_q + 3'd1;
      if (rd_adv) col_q <= col_q + 1'b1;
    end
  end

  nand_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(tmr_len),
    .busy(busy), .done(tmr_done)
  );

  nand_page_store #(.PAGE_BYTES(PAGE_BYTES), .OTP_PAGES(OTP_PAGES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_wr), .wr_col(col_q), .wr_data(bus_din),
    .commit_en(commit_en), .load_en(load_en), .sel_pg(page_q),
    .rd_col(col_q), .rd_byte(page_byte)
  );

  nand_read_port u_rdport (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .kind(kind_q), .status(status),
    .id_idx(id_idx_q), .id_ok(id_ok_q), .busy(busy), .page_byte(page_byte),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R4: a command rejected while busy leaves the command latch and output mode alone
  a_r4_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !rb_n && bus_din != C_STAT && bus_din != C_STAT2 && bus_din != C_RESET)
      |=> ($stable(latch_q) && $stable(kind_q)));
  // R5: reset command always yields busy and a cleared fail flag
  a_r5_reset_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && bus_din == C_RESET) |=> (!rb_n && !fail_q));
  // R10: address count never exceeds five cycles
  a_r10_addr_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    acnt_q <= 3'd5);
  // R8: lock is permanent
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(otp_lock_q) |-> otp_lock_q);
  // R9: writable OTP limit only moves upward
  a_r9_order_up: assert property (@(posedge clk) disable iff (!rst_n)
    otp_next_q >= $past(otp_next_q));
endmodule

// File: tb/tb_nand_status_responder.sv
module tb_nand_status_responder;
  localparam int READ_CYC = 20, PROG_CYC = 40, ERASE_CYC = 60, RST_CYC = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 0, bus_cle = 0, bus_ale = 0, wp_n = 1, rd_req = 0;
  logic [7:0] bus_din = 0, rd_data;
  logic rd_valid, rb_n;
  int checks = 0, fails = 0, cyc = 0;

  nand_status_responder dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_cle(bus_cle), .bus_ale(bus_ale),
    .bus_din(bus_din), .wp_n(wp_n), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .rb_n(rb_n)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic c, input logic a, input logic [7:0] d);
    bus_cle = c; bus_ale = a; bus_din = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_cle = 1'b0; bus_ale = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] d);  bus(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d);  bus(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d);  bus(1'b0, 1'b0, d); endtask
  task automatic adr5(input logic [7:0] col, input logic [7:0] pg);
    adr(col); adr(8'h00); adr(pg); adr(8'h00); adr(8'h00);
  endtask

  task automatic rd(output logic [7:0] v);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check("R11 rd_valid", rd_valid, 1'b1);
    v = rd_data;
  endtask
  task automatic rd_expect(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    rd(v);
    check(tag, v, exp);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rb_n && n < 2000) begin n++; @(negedge clk); end
  endtask
  task automatic settle();
    int n;
    cmd(8'hFF); wait_ready(n);
  endtask

  task automatic t_reset();
    check("R1 rb_n after reset", rb_n, 1'b1);
    @(negedge clk);
    check("R11 no valid without request", rd_valid, 1'b0);
    rd_expect("R1 erased buffer", 8'hFF);
    cmd(8'h70);
    rd_expect("R1 status after reset", 8'hC0);
    rd_expect("R3 status repeats", 8'hC0);
  endtask

  task automatic t_ident();
    cmd(8'h90); adr(8'h00);
    rd_expect("R2 id0", 8'hC8); rd_expect("R2 id1", 8'hDC);
    rd_expect("R2 id2", 8'h90); rd_expect("R2 id3", 8'h95);
    rd_expect("R2 id4", 8'h54); rd_expect("R2 wrap", 8'hC8);
    cmd(8'h90); adr(8'h05);
    rd_expect("R2 bad address", 8'h00);
  endtask

  task automatic t_program_read();
    int n;
    cmd(8'h80); adr5(8'h02, 8'h05); adr(8'h07);   // sixth address cycle: R10
    dat(8'hA0); dat(8'hA1); dat(8'hA2); dat(8'hA3);
    cmd(8'h10); wait_ready(n);
    check("R6 program busy", n, PROG_CYC);
    cmd(8'hF1);
    rd_expect("R3 status via F1", 8'hC0);
    cmd(8'h00); adr5(8'h02, 8'h05); cmd(8'h30);
    rd_expect("R4 page read during busy", 8'hFF);
    wait_ready(n);
    check("R6 read busy", n, READ_CYC - 1);
    rd_expect("R7 byte0 (R10 extra address ignored)", 8'hA0);
    rd_expect("R7 byte1", 8'hA1); rd_expect("R7 byte2", 8'hA2); rd_expect("R7 byte3", 8'hA3);
    cmd(8'h80); adr5(8'h06, 8'h00); dat(8'h11); dat(8'h22); dat(8'h33);
    cmd(8'h10); wait_ready(n);
    adr5(8'h06, 8'h00); cmd(8'h30); wait_ready(n);   // 00h still latched after 10h? no: use 00h
    cmd(8'h00); adr5(8'h06, 8'h00); cmd(8'h30); wait_ready(n);
    rd_expect("R7 col6", 8'h11); rd_expect("R7 col7", 8'h22); rd_expect("R7 wrap col0", 8'h33);
  endtask

  task automatic t_direct_read();
    int n;
    settle();
    adr5(8'h03, 8'h00); cmd(8'h30); wait_ready(n);
    rd_expect("R1 read without 00h", 8'hA1);
  endtask

  task automatic t_busy_and_reset();
    int n;
    cmd(8'h60); adr(8'h01); adr(8'h00); adr(8'h00); cmd(8'hD0); wait_ready(n);
    check("R6 erase busy", n, ERASE_CYC);
    cmd(8'h60); adr(8'h01); adr(8'h00); adr(8'h00); cmd(8'hD0);
    cmd(8'h70);
    rd_expect("R4 status while busy", 8'h80);
    cmd(8'h90);
    rd_expect("R4 90h ignored while busy", 8'h80);
    wait_ready(n);
    cmd(8'hFF); wait_ready(n);
    check("R5 reset from ready", n, RST_CYC);
    cmd(8'h80); adr5(8'h00, 8'h00); cmd(8'h10);
    repeat (3) @(negedge clk);
    cmd(8'hFF); wait_ready(n);
    check("R5 reset aborts program", n, RST_CYC);
    cmd(8'h70);
    rd_expect("R5 status after reset", 8'hC0);
  endtask

  task automatic t_protect();
    wp_n = 1'b0;
    @(negedge clk);
    cmd(8'h70);
    rd_expect("R12 status with wp low", 8'h40);
    cmd(8'h80); adr5(8'h00, 8'h00); cmd(8'h10);
    check("R12 program blocked", rb_n, 1'b1);
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
    check("R12 erase blocked", rb_n, 1'b1);
    wp_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic otp_prog(input logic [7:0] pg, input logic [7:0] d);
    int n;
    cmd(8'h80); adr5(8'h00, pg); dat(d); cmd(8'h10); wait_ready(n);
    cmd(8'h70);
  endtask
  task automatic otp_read(input logic [7:0] pg);
    int n;
    cmd(8'h00); adr5(8'h00, pg); cmd(8'h30); wait_ready(n);
  endtask

  task automatic t_otp();
    int n;
    settle();
    cmd(8'hEF); adr(8'h90); dat(8'h01);
    otp_prog(8'h00, 8'h5A);
    rd_expect("R9 first OTP program ok", 8'hC0);
    otp_read(8'h00);
    rd_expect("R9 OTP data stored", 8'h5A);
    otp_prog(8'h00, 8'h77);
    rd_expect("R9 rewrite fails", 8'hC1);
    otp_read(8'h00);
    rd_expect("R9 data unchanged", 8'h5A);
    settle(); otp_prog(8'd31, 8'h01);
    rd_expect("R9 page out of range fails", 8'hC1);
    settle(); otp_prog(8'h03, 8'h33);
    rd_expect("R9 ascending page ok", 8'hC0);
    otp_prog(8'h02, 8'h22);
    rd_expect("R9 descending page fails", 8'hC1);
    settle();
    cmd(8'h60); adr(8'h04); adr(8'h00); adr(8'h00); cmd(8'hD0);
    check("R9 OTP erase not busy", rb_n, 1'b1);
    cmd(8'h70);
    rd_expect("R9 OTP erase fails", 8'hC1);
    settle();
    cmd(8'h80); adr5(8'h00, 8'h05); dat(8'h55); cmd(8'h10);
    repeat (2) @(negedge clk);
    cmd(8'hFF); wait_ready(n);
    otp_read(8'h05);
    rd_expect("R5 aborted OTP program stores nothing", 8'hFF);
    cmd(8'hEF); adr(8'h90); dat(8'h03);
    settle(); otp_prog(8'h06, 8'h66);
    rd_expect("R8 locked store fails", 8'hC1);
    cmd(8'hEF); adr(8'h90); dat(8'h00);
    settle(); otp_prog(8'h06, 8'h66);
    rd_expect("R8 normal mode after leaving", 8'hC0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_program_read();
    t_direct_read();
    t_busy_and_reset();
    t_protect();
    t_otp();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule